// File: doc/BRIEF.md
# LCD Pixel Output Packer

The packer sits between the pixel pipeline and the LCD timing generator. It takes already processed pixels and turns them into the words that the timing generator shifts onto the panel data bus. A pixel arrives either as one monochrome pixel or as one red, green and blue sub-pixel triple per transfer, on a valid/ready stream. The packer outputs a data word together with a one-cycle strobe.

A static configuration selects the display kind (active-matrix TFT, passive STN monochrome or passive STN colour), single or dual scan, and the STN bus width. On a TFT panel each pixel goes straight out as a 24-bit word. On an STN panel the packer gathers one-bit values into 4-, 8- or 16-bit words, first value in the most significant position. In dual scan, a second input stream feeds the lower half of the panel. Its bits fill the low half of each word, and the upper-panel bits fill the high half. A line-start marker on the first pixel of a line pushes out any partly filled word, padded with zeros. A configuration the panel cannot use raises an error flag and blocks the data path.

Top module: `lcd_pixel_packer`

## Requirements
- R1: In TFT mode (`disp_type_i`=0) each accepted upper-stream pixel appears unchanged on `out_data_o[23:0]`, with `out_strobe_o` high for exactly the cycle after acceptance.
- R2: In STN monochrome mode (`disp_type_i`=1) each pixel contributes its bit 0. Bits fill the word from the most significant position down, and the strobe is raised in the cycle after the word becomes full.
- R3: In STN colour mode (`disp_type_i`=2) each pixel contributes three bits in this order: red = bit 16, green = bit 8, blue = bit 0. A triple may be split across two consecutive words.
- R4: `if_width_i` selects the STN word width: 0 = 4 bits, 1 = 8 bits, 2 = 16 bits. In single scan the word occupies `out_data_o[W-1:0]`, and every higher bit is zero.
- R5: In dual scan (`dual_scan_i`=1) a transfer takes one pixel from each stream, and only when both are valid. `up_ready_o` also requires `lo_valid_i`, and `lo_ready_o` also requires `up_valid_i`. Each word is W bits wide: the upper stream fills bits [W-1:W/2] and the lower stream fills bits [W/2-1:0].
- R6: An accepted pixel with `up_sol_i` high first emits any partly filled STN word, padded with zeros in its unfilled low bits. The new pixel then starts a fresh word.
- R7: The following configurations are illegal: `disp_type_i`=3; TFT with dual scan; STN with `if_width_i`=3; 4-bit in dual scan; 16-bit in single scan. While one is applied, `cfg_err_o` is high, both ready outputs are low and `out_strobe_o` stays low.
- R8: While `rst_ni` is low, the strobe, the output data and any partly filled word are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_type_i | input | 2 | 0 TFT, 1 STN mono, 2 STN colour |
| dual_scan_i | input | 1 | 1 selects dual scan |
| if_width_i | input | 2 | STN word width: 0 4-bit, 1 8-bit, 2 16-bit |
| up_valid_i | input | 1 | Upper-panel pixel valid |
| up_ready_o | output | 1 | Upper-panel pixel accepted |
| up_sol_i | input | 1 | Pixel is the first of a line |
| up_data_i | input | 24 | Upper-panel pixel, R[23:16] G[15:8] B[7:0] |
| lo_valid_i | input | 1 | Lower-panel pixel valid |
| lo_ready_o | output | 1 | Lower-panel pixel accepted |
| lo_data_i | input | 24 | Lower-panel pixel, same layout |
| cfg_err_o | output | 1 | Configuration illegal |
| out_data_o | output | 24 | Packed data word |
| out_strobe_o | output | 1 | Word valid for one cycle |

## Verification
The hardest case to reach is a colour triple that does not fit the space left in the current word. With four-bit halves in dual scan, bits carried over from one pixel sit ahead of the next pixel's bits, and a line start can arrive while that carry is pending. The stimulus runs colour mode at 4-bit and 8-bit half widths, with valids toggled independently on the two streams and line starts at random. Every possible carry depth is therefore flushed. A queue model computes each expected word bit by bit and is compared with the design on every clock.

// File: rtl/lcd_pack_pkg.sv
package lcd_pack_pkg;
  localparam int unsigned CH_W  = 8;
  localparam int unsigned PIX_W = 3 * CH_W;
  localparam int unsigned ACC_W = 16;
  localparam int unsigned CNT_W = $clog2(ACC_W) + 1;

  typedef enum logic [1:0] {
    DISP_TFT   = 2'd0,
    DISP_MONO  = 2'd1,
    DISP_COLOR = 2'd2,
    DISP_BAD   = 2'd3
  } disp_e;

  typedef enum logic [1:0] {
    IFW_4   = 2'd0,
    IFW_8   = 2'd1,
    IFW_16  = 2'd2,
    IFW_BAD = 2'd3
  } ifw_e;
endpackage

// File: rtl/lcd_cfg_decode.sv
module lcd_cfg_decode
  import lcd_pack_pkg::*;
(
  input  logic [1:0]       disp_type_i,
  input  logic             dual_scan_i,
  input  logic [1:0]       if_width_i,
  output logic             err_o,
  output logic             tft_o,
  output logic             color_o,
  output logic [CNT_W-1:0] half_w_o
);
  logic [CNT_W-1:0] word_w;

  assign tft_o   = disp_type_i == DISP_TFT;
  assign color_o = disp_type_i == DISP_COLOR;

  always_comb begin
    unique case (if_width_i)
      IFW_4:   word_w = CNT_W'(4);
      IFW_8:   word_w = CNT_W'(8);
      default: word_w = CNT_W'(ACC_W);
    endcase
    half_w_o = dual_scan_i ? (word_w >> 1) : word_w;
  end

  always_comb begin
    if (disp_type_i == DISP_BAD)  err_o = 1'b1;
    else if (tft_o)               err_o = dual_scan_i;
    else                          err_o = (if_width_i == IFW_BAD)
                                        | ((if_width_i == IFW_4)  &  dual_scan_i)
                                        | ((if_width_i == IFW_16) & ~dual_scan_i);
  end
endmodule

// File: rtl/lcd_pack_lane.sv
module lcd_pack_lane
  import lcd_pack_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             flush_i,
  input  logic [2:0]       bits_i,   // left-aligned new bits
  input  logic [1:0]       nb_i,     // 1 or 3
  input  logic [CNT_W-1:0] half_w_i,
  output logic             emit_o,
  output logic [ACC_W-1:0] word_o    // right-aligned
);
  localparam int unsigned TMP_W = ACC_W + 3;

  logic [ACC_W-1:0] acc_q, acc_d, base_acc, word_left, mask;
  logic [CNT_W-1:0] cnt_q, cnt_d, base_cnt, total;
  logic [TMP_W-1:0] tmp, rem;
  logic             flush_old, full;

  assign flush_old = flush_i && (cnt_q != '0);
  assign base_acc  = flush_i ? '0 : acc_q;
  assign base_cnt  = flush_i ? '0 : cnt_q;
  assign tmp       = {base_acc, 3'b000} | ({bits_i, {ACC_W{1'b0}}} >> base_cnt);
  assign total     = base_cnt + CNT_W'(nb_i);
  assign full      = total >= half_w_i;
  assign mask      = ~({ACC_W{1'b1}} >> half_w_i);
  assign rem       = tmp << half_w_i;
  assign emit_o    = take_i && (flush_old || full);
  assign word_left = flush_old ? acc_q : (tmp[TMP_W-1:3] & mask);
  assign word_o    = word_left >> (CNT_W'(ACC_W) - half_w_i);

  always_comb begin
    acc_d = acc_q;
    cnt_d = cnt_q;
    if (take_i) begin
      if (full) begin
        acc_d = rem[TMP_W-1:3];
        cnt_d = total - half_w_i;
      end else begin
        acc_d = tmp[TMP_W-1:3];
        cnt_d = total;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  a_r2_fill_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_w_i != '0) |-> (cnt_q < half_w_i))
    else $error("a_r2_fill_bound");

  a_r6_flush_emits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && flush_i && cnt_q != '0) |-> emit_o)
    else $error("a_r6_flush_emits");

  a_r6_fresh_after_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && flush_i) |=> (cnt_q == $past(CNT_W'(nb_i))))
    else $error("a_r6_fresh_after_flush");
endmodule

// File: rtl/lcd_pixel_packer.sv
module lcd_pixel_packer
  import lcd_pack_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        disp_type_i,
  input  logic              dual_scan_i,
  input  logic [1:0]        if_width_i,
  input  logic              up_valid_i,
  output logic              up_ready_o,
  input  logic              up_sol_i,
  input  logic [PIX_W-1:0]  up_data_i,
  input  logic              lo_valid_i,
  output logic              lo_ready_o,
  input  logic [PIX_W-1:0]  lo_data_i,
  output logic              cfg_err_o,
  output logic [PIX_W-1:0]  out_data_o,
  output logic              out_strobe_o
);
  logic             is_tft, is_color, fire;
  logic [CNT_W-1:0] half_w;
  logic [PIX_W-1:0] lane_pix  [2];
  logic [1:0]       lane_take, lane_emit;
  logic [ACC_W-1:0] lane_word [2];
  logic [PIX_W-1:0] next_data;
  logic             next_stb;

  lcd_cfg_decode u_cfg (
    .disp_type_i (disp_type_i),
    .dual_scan_i (dual_scan_i),
    .if_width_i  (if_width_i),
    .err_o       (cfg_err_o),
    .tft_o       (is_tft),
    .color_o     (is_color),
    .half_w_o    (half_w)
  );

  assign up_ready_o = !cfg_err_o && (!dual_scan_i || lo_valid_i);
  assign lo_ready_o = !cfg_err_o && dual_scan_i && up_valid_i;
  assign fire       = up_valid_i && up_ready_o;

  assign lane_pix[0]  = up_data_i;
  assign lane_pix[1]  = lo_data_i;
  assign lane_take[0] = fire && !is_tft;
  assign lane_take[1] = fire && !is_tft && dual_scan_i;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [2:0] bits;
    assign bits = is_color ? {lane_pix[g][2*CH_W], lane_pix[g][CH_W], lane_pix[g][0]}
                           : {lane_pix[g][0], 2'b00};
    lcd_pack_lane u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .take_i   (lane_take[g]),
      .flush_i  (up_sol_i),
      .bits_i   (bits),
      .nb_i     (is_color ? 2'd3 : 2'd1),
      .half_w_i (half_w),
      .emit_o   (lane_emit[g]),
      .word_o   (lane_word[g])
    );
  end

  always_comb begin
    next_stb  = 1'b0;
    next_data = out_data_o;
    if (fire && is_tft) begin
      next_stb  = 1'b1;
      next_data = up_data_i;
    end else if (lane_emit[0]) begin
      next_stb  = 1'b1;
      next_data = PIX_W'(lane_word[0]);
      if (dual_scan_i) next_data = (PIX_W'(lane_word[0]) << half_w) | PIX_W'(lane_word[1]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_strobe_o <= 1'b0;
      out_data_o   <= '0;
    end else begin
      out_strobe_o <= next_stb;
      out_data_o   <= next_data;
    end
  end

  a_r1_tft_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && is_tft) |=> (out_strobe_o && out_data_o == $past(up_data_i)))
    else $error("a_r1_tft_strobe");

  a_r5_lanes_lockstep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dual_scan_i && !is_tft) |-> (lane_emit[0] == lane_emit[1]))
    else $error("a_r5_lanes_lockstep");

  a_r5_pair_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && dual_scan_i) |-> (lo_valid_i && lo_ready_o))
    else $error("a_r5_pair_valid");

  a_r7_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_err_o && $past(cfg_err_o)) |-> !out_strobe_o)
    else $error("a_r7_err_quiet");
endmodule

// File: tb/lcd_pixel_packer_tb.sv
module lcd_pixel_packer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  disp_type_i = 2'd0;
  logic        dual_scan_i = 1'b0;
  logic [1:0]  if_width_i = 2'd1;
  logic        up_valid_i = 1'b0, up_sol_i = 1'b0, lo_valid_i = 1'b0;
  logic [23:0] up_data_i = '0, lo_data_i = '0;
  logic        up_ready_o, lo_ready_o, cfg_err_o, out_strobe_o;
  logic [23:0] out_data_o;

  lcd_pixel_packer u_dut (.*);

  always #2 clk_i = ~clk_i;

  int vectors = 0, fails = 0;
  bit qu[$];
  bit ql[$];
  bit exp_stb = 0;
  int exp_data = 0;
  string exp_tag = "R8";
  bit m_err, m_dual, m_tft, m_color;
  int m_h;

  task automatic check(input string tag, input int act, input int expv);
    vectors++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic int pop_word(input bit lower);
    int w = 0;
    for (int i = 0; i < m_h; i++) begin
      bit b = 0;
      if (lower) begin if (ql.size() > 0) b = ql.pop_front(); end
      else begin if (qu.size() > 0) b = qu.pop_front(); end
      w = (w << 1) | int'(b);
    end
    return w;
  endfunction

  function automatic int emit_word();
    int w = pop_word(0);
    if (m_dual) w = (w << m_h) | pop_word(1);
    return w;
  endfunction

  task automatic push_bits(input logic [23:0] d, input bit lower);
    if (m_color) begin
      if (lower) begin ql.push_back(d[16]); ql.push_back(d[8]); ql.push_back(d[0]); end
      else begin qu.push_back(d[16]); qu.push_back(d[8]); qu.push_back(d[0]); end
    end else begin
      if (lower) ql.push_back(d[0]); else qu.push_back(d[0]);
    end
  endtask

  // one cycle: drive after a negedge, model, compare at next negedge
  task automatic step(input bit vu, input bit vl, input bit sol);
    bit rdy_u, rdy_l;
    up_valid_i = vu; lo_valid_i = vl; up_sol_i = sol;
    up_data_i = 24'($urandom); lo_data_i = 24'($urandom);
    #1;
    rdy_u = !m_err && (!m_dual || vl);
    rdy_l = !m_err && m_dual && vu;
    check("R7 cfg_err", int'(cfg_err_o), int'(m_err));
    check("R5 R7 up_ready", int'(up_ready_o), int'(rdy_u));
    check("R5 R7 lo_ready", int'(lo_ready_o), int'(rdy_l));
    exp_stb = 0;
    if (vu && rdy_u) begin
      if (m_tft) begin
        exp_stb = 1; exp_data = int'(up_data_i); exp_tag = "R1";
      end else begin
        if (sol && qu.size() > 0) begin
          exp_stb = 1; exp_data = emit_word(); exp_tag = "R6";
          qu.delete(); ql.delete();
        end
        push_bits(up_data_i, 0);
        if (m_dual) push_bits(lo_data_i, 1);
        if (qu.size() >= m_h) begin
          exp_stb = 1; exp_data = emit_word();
          exp_tag = m_dual ? "R5 R4" : (m_color ? "R3 R4" : "R2 R4");
        end
      end
    end
    @(negedge clk_i);
    check({exp_tag, " strobe"}, int'(out_strobe_o), int'(exp_stb));
    if (exp_stb) check({exp_tag, " data"}, int'(out_data_o), exp_data);
  endtask

  task automatic run_cfg(input int dt, input bit ds, input int iw, input int n);
    rst_ni = 0; up_valid_i = 0; lo_valid_i = 0; up_sol_i = 0;
    disp_type_i = 2'(dt); dual_scan_i = ds; if_width_i = 2'(iw);
    m_tft = (dt == 0); m_color = (dt == 2); m_dual = ds;
    m_h = (iw == 0) ? 4 : (iw == 1) ? 8 : 16;
    if (ds) m_h = m_h / 2;
    m_err = (dt == 3) || (m_tft && ds) ||
            (!m_tft && (iw == 3 || (iw == 0 && ds) || (iw == 2 && !ds)));
    qu.delete(); ql.delete();
    @(negedge clk_i); @(negedge clk_i);
    check("R8 reset strobe", int'(out_strobe_o), 0);
    check("R8 reset data", int'(out_data_o), 0);
    rst_ni = 1;
    for (int i = 0; i < n; i++)
      step(($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 7) == 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    run_cfg(0, 0, 1, 60);   // TFT
    run_cfg(1, 0, 0, 120);  // mono 4
    run_cfg(1, 0, 1, 120);  // mono 8
    run_cfg(2, 0, 0, 120);  // colour 4
    run_cfg(2, 0, 1, 120);  // colour 8
    run_cfg(1, 1, 1, 120);  // mono dual 8
    run_cfg(1, 1, 2, 120);  // mono dual 16
    run_cfg(2, 1, 1, 150);  // colour dual 8, 4-bit halves
    run_cfg(2, 1, 2, 150);  // colour dual 16
    run_cfg(0, 1, 1, 30);   // illegal: TFT dual
    run_cfg(1, 1, 0, 30);   // illegal: 4-bit dual
    run_cfg(2, 0, 2, 30);   // illegal: 16-bit single
    run_cfg(1, 0, 3, 30);   // illegal width code
    run_cfg(3, 0, 1, 30);   // illegal display code
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule